// File: doc/BRIEF.md
# 64b/66b Line Scrambler with Bit-Slip Realignment

This block is the line-side stage between a 64b/66b block coder and a serializer. It has a transmit path and a receive path that share one clock, one clock enable and two static controls. On the transmit path each 66-bit block is a 64-bit payload plus a 2-bit sync header. The payload passes through a self-synchronizing scrambler with the polynomial 1 + x^39 + x^58, and the header bypasses it. The 66-bit result can then be rotated across the boundary between consecutive blocks by a bit offset that steps on a slip pulse. Last, the data and the header can each be mirrored before they leave the block.

The receive path takes a raw 66-bit block from the line. It mirrors the block first when reversal is selected and then descrambles the payload. Because the descrambler's state is built from the received bits, it locks to any transmitter within one block. Both paths register their outputs, so each result appears one enabled clock after its input. The scramble control turns the scrambler and the descrambler off together. When off, the payloads pass through unchanged and neither scrambler state moves.

The offset logic is a counter over 66 positions: zero, one step per slip, and a wrap from the last position back to zero. The block has no separate control state machine.

Top module: `lane_scramble_align`

## Requirements
- R1: After reset all outputs are zero, both scrambler states are all ones and the bit offset is zero.
- R2: When scrambling, transmit payload bits are processed from bit 0 up to bit 63. Each output bit is the input bit XOR state bit 38 XOR state bit 57 of a 58-bit state. The state then shifts left by one with the output bit entering bit 0.
- R3: The 2-bit header is never scrambled. With reversal off and offset zero, tx_hdr_out equals the header sampled on the previous enabled edge.
- R4: The receive descrambler uses the same taps and bit order, but the received (scrambled) bit enters the state. When fed the transmit output, it returns the original payload from the second block on.
- R5: With scr_en low, both payloads pass through unscrambled and neither scrambler state changes.
- R6: A slip sampled high on an enabled edge raises the offset by one, and the new offset is applied to that same edge's block. Offset 65 followed by a slip gives offset 0.
- R7: With offset k, the transmit 66-bit word {data,hdr} (hdr in bits 1:0) forms output bit j as block bit j-k for j>=k. For j<k, output bit j is bit j+66-k of the previous enabled edge's block. The result is split back as hdr = bits 1:0 and data = bits 65:2.
- R8: With rev_en high, data bit i maps to bit 63-i and the two header bits swap. The transmit path applies this last, and the receive path applies it before descrambling.
- R9: On a clock where clk_en is low, no output, scrambler state, offset or stored block changes, and slip is ignored.
- R10: Each output is registered and reflects the inputs sampled on the previous enabled rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable for all state |
| scr_en | input | 1 | Scrambling and descrambling on |
| rev_en | input | 1 | Bit reversal on |
| slip | input | 1 | Advance the transmit bit offset by one |
| tx_data_in | input | 64 | Transmit payload |
| tx_hdr_in | input | 2 | Transmit sync header |
| tx_data_out | output | 64 | Line-side transmit payload |
| tx_hdr_out | output | 2 | Line-side transmit header |
| rx_data_in | input | 64 | Line-side receive payload |
| rx_hdr_in | input | 2 | Line-side receive header |
| rx_data_out | output | 64 | Descrambled receive payload |
| rx_hdr_out | output | 2 | Receive header |

## Verification
On every cycle the assertions check the following. Outputs and the offset hold while the enable is low. The offset stays below 66, steps by one per slip and wraps to zero. The header and the unscrambled payloads pass straight through when no rotation or reversal is active. The exact scrambled values, the rotation across block boundaries at each of the 66 offsets, the mirroring, and the descrambler's self-synchronization in a loopback can only be shown by the bench's scenarios. The bench compares these against its own bit-serial model.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int STATE_W = 58;
    localparam int TAP_A   = 38;
    localparam int TAP_B   = 57;
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr
    import scr_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int DESCRAMBLE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    logic [DATA_W-1:0]  feed;

    always_comb begin
        logic [STATE_W-1:0] st;
        logic               ob;
        st   = state_q;
        dout = '0;
        for (int i = 0; i < DATA_W; i++) begin
            ob      = din[i] ^ st[TAP_A] ^ st[TAP_B];
            dout[i] = ob;
            st      = {st[STATE_W-2:0], feed[i] ^ (DESCRAMBLE != 0 ? 1'b0 : ob)};
        end
        state_d = st;
    end

    generate
        if (DESCRAMBLE != 0) begin : g_rx_feed
            assign feed = din;
        end else begin : g_tx_feed
            assign feed = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '1;
        end else if (adv) begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/scr_rotate.sv
module scr_rotate #(
    parameter int BLK_W = 66,
    parameter int OFF_W = $clog2(BLK_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             slip,
    input  logic [BLK_W-1:0] blk_in,
    output logic [BLK_W-1:0] blk_out,
    output logic [OFF_W-1:0] off_o
);
    localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(BLK_W - 1);

    logic [OFF_W-1:0]   off_q;
    logic [OFF_W-1:0]   off_next;
    logic [BLK_W-1:0]   last_q;
    logic [2*BLK_W-1:0] wide;
    logic [OFF_W:0]     shamt;

    always_comb begin
        off_next = off_q;
        if (slip) begin
            off_next = (off_q == OFF_MAX) ? '0 : off_q + 1'b1;
        end
        shamt   = (OFF_W+1)'(BLK_W) - {1'b0, off_next};
        wide    = {blk_in, last_q} >> shamt;
        blk_out = wide[BLK_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            last_q <= '0;
        end else if (adv) begin
            off_q  <= off_next;
            last_q <= blk_in;
        end
    end

    assign off_o = off_q;
endmodule

// File: rtl/scr_mirror.sv
module scr_mirror #(
    parameter int W = 64
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] flipped;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign flipped[i] = din[W-1-i];
        end
    endgenerate

    assign dout = en ? flipped : din;
endmodule

// File: rtl/lane_scramble_align.sv
module lane_scramble_align #(
    parameter int DATA_W = 64,
    parameter int HDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              scr_en,
    input  logic              rev_en,
    input  logic              slip,
    input  logic [DATA_W-1:0] tx_data_in,
    input  logic [HDR_W-1:0]  tx_hdr_in,
    output logic [DATA_W-1:0] tx_data_out,
    output logic [HDR_W-1:0]  tx_hdr_out,
    input  logic [DATA_W-1:0] rx_data_in,
    input  logic [HDR_W-1:0]  rx_hdr_in,
    output logic [DATA_W-1:0] rx_data_out,
    output logic [HDR_W-1:0]  rx_hdr_out
);
    localparam int BLK_W = DATA_W + HDR_W;
    localparam int OFF_W = $clog2(BLK_W);

    logic [DATA_W-1:0] tx_scr, tx_pay;
    logic [BLK_W-1:0]  tx_blk, tx_rot;
    logic [DATA_W-1:0] tx_dm;
    logic [HDR_W-1:0]  tx_hm;
    logic [OFF_W-1:0]  offset_q;
    logic [DATA_W-1:0] rx_dm, rx_dscr, rx_pay;
    logic [HDR_W-1:0]  rx_hm;

    scr_lfsr #(.DATA_W(DATA_W), .DESCRAMBLE(0)) u_tx_scr (
        .clk(clk), .rst(rst), .adv(clk_en & scr_en),
        .din(tx_data_in), .dout(tx_scr)
    );

    assign tx_pay = scr_en ? tx_scr : tx_data_in;
    assign tx_blk = {tx_pay, tx_hdr_in};

    scr_rotate #(.BLK_W(BLK_W), .OFF_W(OFF_W)) u_rot (
        .clk(clk), .rst(rst), .adv(clk_en), .slip(slip),
        .blk_in(tx_blk), .blk_out(tx_rot), .off_o(offset_q)
    );

    scr_mirror #(.W(DATA_W)) u_tx_dmir (
        .en(rev_en), .din(tx_rot[BLK_W-1:HDR_W]), .dout(tx_dm)
    );
    scr_mirror #(.W(HDR_W)) u_tx_hmir (
        .en(rev_en), .din(tx_rot[HDR_W-1:0]), .dout(tx_hm)
    );

    scr_mirror #(.W(DATA_W)) u_rx_dmir (
        .en(rev_en), .din(rx_data_in), .dout(rx_dm)
    );
    scr_mirror #(.W(HDR_W)) u_rx_hmir (
        .en(rev_en), .din(rx_hdr_in), .dout(rx_hm)
    );

    scr_lfsr #(.DATA_W(DATA_W), .DESCRAMBLE(1)) u_rx_scr (
        .clk(clk), .rst(rst), .adv(clk_en & scr_en),
        .din(rx_dm), .dout(rx_dscr)
    );

    assign rx_pay = scr_en ? rx_dscr : rx_dm;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data_out <= '0;
            tx_hdr_out  <= '0;
            rx_data_out <= '0;
            rx_hdr_out  <= '0;
        end else if (clk_en) begin
            tx_data_out <= tx_dm;
            tx_hdr_out  <= tx_hm;
            rx_data_out <= rx_pay;
            rx_hdr_out  <= rx_hm;
        end
    end
endmodule

// File: rtl/lane_scramble_align_chk.sv
module lane_scramble_align_chk #(
    parameter int DATA_W = 64,
    parameter int HDR_W  = 2,
    parameter int OFF_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic              scr_en,
    input logic              rev_en,
    input logic              slip,
    input logic [DATA_W-1:0] tx_data_in,
    input logic [HDR_W-1:0]  tx_hdr_in,
    input logic [DATA_W-1:0] tx_data_out,
    input logic [HDR_W-1:0]  tx_hdr_out,
    input logic [DATA_W-1:0] rx_data_in,
    input logic [DATA_W-1:0] rx_data_out,
    input logic [HDR_W-1:0]  rx_hdr_out,
    input logic [OFF_W-1:0]  offset_q
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(DATA_W + HDR_W - 1);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(tx_data_out) && $stable(tx_hdr_out)
                    && $stable(rx_data_out) && $stable(rx_hdr_out) && $stable(offset_q));

    assert_offset_range_R6: assert property (@(posedge clk) disable iff (rst)
        offset_q <= LAST_OFF);

    assert_slip_step_R6: assert property (@(posedge clk) disable iff (rst)
        clk_en && slip && offset_q != LAST_OFF |=> offset_q == $past(offset_q) + 1'b1);

    assert_slip_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        clk_en && slip && offset_q == LAST_OFF |=> offset_q == '0);

    assert_no_slip_hold_R6: assert property (@(posedge clk) disable iff (rst)
        clk_en && !slip |=> $stable(offset_q));

    assert_hdr_bypass_R3: assert property (@(posedge clk) disable iff (rst)
        clk_en && !rev_en && !slip && offset_q == '0 |=> tx_hdr_out == $past(tx_hdr_in));

    assert_tx_plain_R5: assert property (@(posedge clk) disable iff (rst)
        clk_en && !scr_en && !rev_en && !slip && offset_q == '0
        |=> tx_data_out == $past(tx_data_in));

    assert_rx_plain_R5: assert property (@(posedge clk) disable iff (rst)
        clk_en && !scr_en && !rev_en |=> rx_data_out == $past(rx_data_in));
endmodule

bind lane_scramble_align lane_scramble_align_chk #(
    .DATA_W(DATA_W), .HDR_W(HDR_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/tb_lane_scramble_align.sv
module tb_lane_scramble_align;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, clk_en, scr_en, rev_en, slip;
    logic [63:0] tx_data_in, tx_data_out, rx_data_in, rx_data_out;
    logic [1:0]  tx_hdr_in, tx_hdr_out, rx_hdr_in, rx_hdr_out;

    lane_scramble_align dut (.*);

    int total = 0;
    int bad   = 0;

    logic [57:0] m_tx_st, m_rx_st;
    logic [65:0] m_last;
    int          m_off;
    logic [63:0] e_txd, e_rxd;
    logic [1:0]  e_txh, e_rxh;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tx_st = '1; m_rx_st = '1; m_last = '0; m_off = 0;
        e_txd = '0; e_rxd = '0; e_txh = '0; e_rxh = '0;
    endtask

    task automatic model_tx(input logic [63:0] d, input logic [1:0] h, input logic sl);
        logic [63:0] s;
        logic [65:0] w, o;
        logic        b;
        s = d;
        if (scr_en) begin
            for (int i = 0; i < 64; i++) begin
                b = d[i] ^ m_tx_st[38] ^ m_tx_st[57];
                s[i] = b;
                m_tx_st = {m_tx_st[56:0], b};
            end
        end
        if (sl) m_off = (m_off + 1) % 66;
        w = {s, h};
        for (int k = 0; k < 66; k++)
            o[k] = (k >= m_off) ? w[k - m_off] : m_last[k + 66 - m_off];
        m_last = w;
        e_txd = o[65:2];
        e_txh = o[1:0];
        if (rev_en) begin
            for (int i = 0; i < 64; i++) e_txd[i] = o[65 - i];
            e_txh = {o[0], o[1]};
        end
    endtask

    task automatic model_rx(input logic [63:0] d, input logic [1:0] h);
        logic [63:0] r;
        r = d;
        e_rxh = h;
        if (rev_en) begin
            for (int i = 0; i < 64; i++) r[i] = d[63 - i];
            e_rxh = {h[0], h[1]};
        end
        e_rxd = r;
        if (scr_en) begin
            for (int i = 0; i < 64; i++) begin
                e_rxd[i] = r[i] ^ m_rx_st[38] ^ m_rx_st[57];
                m_rx_st = {m_rx_st[56:0], r[i]};
            end
        end
    endtask

    task automatic step(input string tag, input logic [63:0] td, input logic [1:0] th,
                        input logic [63:0] rd, input logic [1:0] rh,
                        input logic en, input logic sl);
        @(negedge clk);
        tx_data_in = td; tx_hdr_in = th; rx_data_in = rd; rx_hdr_in = rh;
        clk_en = en; slip = sl;
        if (en) begin
            model_tx(td, th, sl);
            model_rx(rd, rh);
        end
        @(posedge clk);
        #1;
        chk({tag, " tx_data (R10)"}, tx_data_out, e_txd);
        chk({tag, " tx_hdr"}, {62'd0, tx_hdr_out}, {62'd0, e_txh});
        chk({tag, " rx_data (R10)"}, rx_data_out, e_rxd);
        chk({tag, " rx_hdr"}, {62'd0, rx_hdr_out}, {62'd0, e_rxh});
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] prev_d, d;
        rst = 1'b1; clk_en = 1'b0; scr_en = 1'b1; rev_en = 1'b0; slip = 1'b0;
        tx_data_in = '0; tx_hdr_in = '0; rx_data_in = '0; rx_hdr_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R1 reset tx_data", tx_data_out, 64'd0);
        chk("R1 reset rx_data", rx_data_out, 64'd0);
        chk("R1 reset hdrs", {60'd0, tx_hdr_out, rx_hdr_out}, 64'd0);

        // R1/R2: zero payload right after reset exposes the all-ones seed
        step("R1 R2 seed", 64'd0, 2'b01, 64'd0, 2'b10, 1'b1, 1'b0);
        // R2 R3 R4: scrambled stream, header bypass, model descrambler
        for (int n = 0; n < 40; n++)
            step("R2 R3 R4 scramble", rnd64(), 2'(n), rnd64(), 2'(n + 1), 1'b1, 1'b0);
        // R4: loopback, tx output fed to rx
        prev_d = '0;
        for (int n = 0; n < 20; n++) begin
            d = rnd64();
            step("R4 loop", d, 2'b10, tx_data_out, tx_hdr_out, 1'b1, 1'b0);
            if (n >= 2) chk("R4 loopback recovers payload", rx_data_out, prev_d);
            prev_d = tx_data_in;
            prev_d = (n >= 1) ? prev_d : prev_d;
        end
        // R9: enable low with slip and changing inputs
        for (int n = 0; n < 6; n++)
            step("R9 idle", rnd64(), 2'b11, rnd64(), 2'b00, 1'b0, 1'b1);
        step("R9 resume", rnd64(), 2'b01, rnd64(), 2'b01, 1'b1, 1'b0);
        // R5: scrambling off
        scr_en = 1'b0;
        for (int n = 0; n < 10; n++)
            step("R5 plain", rnd64(), 2'b01, rnd64(), 2'b10, 1'b1, 1'b0);
        // R6 R7: sweep every offset and the wrap, scrambling off
        for (int k = 0; k < 67; k++) begin
            step("R6 R7 slip", rnd64(), 2'b01, rnd64(), 2'b01, 1'b1, 1'b1);
            step("R7 hold", rnd64(), 2'b10, rnd64(), 2'b10, 1'b1, 1'b0);
            step("R7 hold2", rnd64(), 2'b01, rnd64(), 2'b11, 1'b1, 1'b0);
        end
        // R5: state frozen while off, so scrambling resumes from the held state
        scr_en = 1'b1;
        for (int n = 0; n < 10; n++)
            step("R5 R2 resume", rnd64(), 2'b01, rnd64(), 2'b10, 1'b1, 1'b0);
        // R8: reversal with scrambling at several offsets
        rev_en = 1'b1;
        for (int k = 0; k < 20; k++) begin
            step("R8 rev slip", rnd64(), 2'b01, rnd64(), 2'b01, 1'b1, k[1]);
            step("R8 rev", rnd64(), 2'b10, rnd64(), 2'b10, 1'b1, 1'b0);
        end
        scr_en = 1'b0;
        for (int n = 0; n < 8; n++)
            step("R8 rev plain", 64'h1 << n, 2'b01, 64'h3 << n, 2'b01, 1'b1, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule